// File: doc/BRIEF.md
# Non-Maskable Interrupt Acknowledge Sequencer

This block carries out an 8-bit CPU core's response to a non-maskable interrupt, one clock at a time. A rising edge on the request input is taken only while the block is idle. The block then runs a dummy opcode-fetch machine cycle and discards the byte it reads. Wait is honoured only at the T2/T3 boundary of that cycle, and the refresh part is stretched to three clocks. Next the block writes the return address onto the stack in two three-clock write cycles. Finally it hands the core a new program counter, a new stack pointer and new interrupt-enable flags.

The surrounding core supplies its current program counter, stack pointer, first enable flag and halted flag. When the core is halted, its program counter is taken to point at the halt opcode, and the return address becomes that value plus one. The core loads the updated registers in the clock where the one-clock done pulse is high.

Top module: `nmi_ack_seq`

## Requirements
- R1: While rst_n is low, mreq, rd, wr, m1, rfsh and done are 0, addr and wdata are 0, and pc_out, sp_out, iff1_out and iff2_out are 0.
- R2: A 0-to-1 change of nmi_req seen at a clock edge while the block is idle starts a sequence in the next clock. A request held high does not start a second sequence. Edges that arrive between the first clock of a sequence and its done clock are ignored.
- R3: Clock 1 (T1) and clock 2 (T2) of a sequence drive mreq=1, rd=1 and m1=1, with addr equal to the return address. Outside bus cycles, addr and wdata are 0.
- R4: wait_req is sampled only at the end of T2 and at the end of each inserted wait clock. Each sample that is high adds one more clock with mreq, rd and m1 held. wait_req in any other clock has no effect.
- R5: After the fetch come exactly three refresh clocks with mreq=1, rfsh=1, rd=0, m1=0 and addr=0.
- R6: The high byte of the return address is written at sp_i-1 (modulo 2^16), then the low byte at sp_i-2. Each write cycle lasts three clocks, with mreq high in all three and wr high in the second and third. sp_out becomes sp_i-2.
- R7: With no waits, done is high in clock 12 of the sequence and nowhere else, and is exactly one clock wide. In that clock pc_out is 0x0066. Each wait clock delays done by one clock.
- R8: In the done clock, iff2_out equals the iff1_i that was captured at the start, and iff1_out is 0.
- R9: halt_o follows halted_i while idle. It stays high for clock 1 of the sequence and is 0 from clock 2 onward.
- R10: The return address is pc_i+1 (modulo 2^16) when halted_i was high at the start, and pc_i otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable interrupt request, edge-detected |
| wait_req | input | 1 | Active-high wait request |
| halted_i | input | 1 | Core is in the halted state |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| iff1_i | input | 1 | Current first interrupt-enable flag |
| mreq | output | 1 | Memory request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| m1 | output | 1 | Opcode-fetch cycle indicator |
| rfsh | output | 1 | Refresh strobe |
| addr | output | 16 | Address bus |
| wdata | output | 8 | Write data |
| halt_o | output | 1 | Halted indication toward the core |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 16 | Updated stack pointer |
| iff1_out | output | 1 | Updated first enable flag |
| iff2_out | output | 1 | Updated second enable flag |
| done | output | 1 | One-clock pulse when the updated values are valid |

## Verification
Sequences run with zero to three wait clocks, and the strobe trace is compared clock by clock against a schedule computed from the wait count. This separates a wait inserted in the wrong place from a refresh or write phase of the wrong length. Some runs also drive wait_req high in T1, in refresh and in the write clocks, which shows that it is sampled only at T2 and in wait clocks. The halted and running starts, both enable-flag values, and stack and program counters chosen to wrap around distinguish the plus-one return address, the byte order of the push and the borrow in the stack arithmetic. Runs that toggle or hold the request during and after a sequence, and a reset in the middle of a sequence, show that each edge is serviced once.

// File: rtl/nmi_seq_pkg.sv
package nmi_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F1, ST_F2, ST_FW,
    ST_R1, ST_R2, ST_R3,
    ST_H1, ST_H2, ST_H3,
    ST_L1, ST_L2, ST_L3,
    ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic mreq;
    logic rd;
    logic wr;
    logic m1;
    logic rfsh;
    logic done;
  } bus_strb_t;

endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic arm_i,
  output logic start_o
);

  logic prev_q;
  logic prev_n;

  always_comb begin
    prev_n  = req_i;
    start_o = req_i & ~prev_q & arm_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_n;
  end

endmodule

// File: rtl/nmi_seq_ctrl.sv
module nmi_seq_ctrl
  import nmi_seq_pkg::*;
#(
  parameter int unsigned        DW      = 8,
  parameter logic [2*DW-1:0]    NMI_VEC = 16'h0066
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            wait_i,
  input  logic            halted_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] sp_i,
  input  logic            iff1_i,
  output seq_st_e         st_o,
  output logic [2*DW-1:0] ret_o,
  output logic [2*DW-1:0] sp_cap_o,
  output logic [2*DW-1:0] pc_o,
  output logic [2*DW-1:0] sp_o,
  output logic            iff1_o,
  output logic            iff2_o
);

  localparam int unsigned AW = 2 * DW;

  seq_st_e       st_q, st_n;
  logic [AW-1:0] ret_n;
  logic          cap_en, fin_en;
  logic          iff1_cap_q;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_n = ST_F1;
      ST_F1:   st_n = ST_F2;
      ST_F2:   st_n = wait_i ? ST_FW : ST_R1;
      ST_FW:   st_n = wait_i ? ST_FW : ST_R1;
      ST_R1:   st_n = ST_R2;
      ST_R2:   st_n = ST_R3;
      ST_R3:   st_n = ST_H1;
      ST_H1:   st_n = ST_H2;
      ST_H2:   st_n = ST_H3;
      ST_H3:   st_n = ST_L1;
      ST_L1:   st_n = ST_L2;
      ST_L2:   st_n = ST_L3;
      ST_L3:   st_n = ST_FIN;
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    cap_en = (st_q == ST_IDLE) && start_i;
    fin_en = (st_q == ST_L3);
    ret_n  = halted_i ? (pc_i + AW'(1)) : pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ret_o      <= '0;
      sp_cap_o   <= '0;
      iff1_cap_q <= 1'b0;
      pc_o       <= '0;
      sp_o       <= '0;
      iff1_o     <= 1'b0;
      iff2_o     <= 1'b0;
    end else begin
      st_q <= st_n;
      if (cap_en) begin
        ret_o      <= ret_n;
        sp_cap_o   <= sp_i;
        iff1_cap_q <= iff1_i;
      end
      if (fin_en) begin
        pc_o   <= NMI_VEC;
        sp_o   <= sp_cap_o - AW'(2);
        iff1_o <= 1'b0;
        iff2_o <= iff1_cap_q;
      end
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/nmi_bus_dec.sv
module nmi_bus_dec
  import nmi_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  seq_st_e         st_i,
  input  logic [2*DW-1:0] ret_i,
  input  logic [2*DW-1:0] sp_i,
  output bus_strb_t       strb_o,
  output logic [2*DW-1:0] addr_o,
  output logic [DW-1:0]   wdata_o
);

  localparam int unsigned AW = 2 * DW;

  always_comb begin
    strb_o  = '0;
    addr_o  = '0;
    wdata_o = '0;
    case (st_i)
      ST_F1, ST_F2, ST_FW: begin
        strb_o.mreq = 1'b1;
        strb_o.rd   = 1'b1;
        strb_o.m1   = 1'b1;
        addr_o      = ret_i;
      end
      ST_R1, ST_R2, ST_R3: begin
        strb_o.mreq = 1'b1;
        strb_o.rfsh = 1'b1;
      end
      ST_H1, ST_H2, ST_H3: begin
        strb_o.mreq = 1'b1;
        strb_o.wr   = (st_i != ST_H1);
        addr_o      = sp_i - AW'(1);
        wdata_o     = ret_i[AW-1:DW];
      end
      ST_L1, ST_L2, ST_L3: begin
        strb_o.mreq = 1'b1;
        strb_o.wr   = (st_i != ST_L1);
        addr_o      = sp_i - AW'(2);
        wdata_o     = ret_i[DW-1:0];
      end
      ST_FIN: strb_o.done = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/nmi_ack_seq.sv
module nmi_ack_seq
  import nmi_seq_pkg::*;
#(
  parameter int unsigned     DW      = 8,
  parameter logic [2*DW-1:0] NMI_VEC = 16'h0066
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_req,
  input  logic            wait_req,
  input  logic            halted_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] sp_i,
  input  logic            iff1_i,
  output logic            mreq,
  output logic            rd,
  output logic            wr,
  output logic            m1,
  output logic            rfsh,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   wdata,
  output logic            halt_o,
  output logic [2*DW-1:0] pc_out,
  output logic [2*DW-1:0] sp_out,
  output logic            iff1_out,
  output logic            iff2_out,
  output logic            done
);

  localparam int unsigned AW = 2 * DW;

  seq_st_e       st;
  logic          start;
  logic [AW-1:0] ret, sp_cap;
  bus_strb_t     strb;

  nmi_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (nmi_req),
    .arm_i   (st == ST_IDLE),
    .start_o (start)
  );

  nmi_seq_ctrl #(.DW(DW), .NMI_VEC(NMI_VEC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .wait_i   (wait_req),
    .halted_i (halted_i),
    .pc_i     (pc_i),
    .sp_i     (sp_i),
    .iff1_i   (iff1_i),
    .st_o     (st),
    .ret_o    (ret),
    .sp_cap_o (sp_cap),
    .pc_o     (pc_out),
    .sp_o     (sp_out),
    .iff1_o   (iff1_out),
    .iff2_o   (iff2_out)
  );

  nmi_bus_dec #(.DW(DW)) u_bus (
    .st_i    (st),
    .ret_i   (ret),
    .sp_i    (sp_cap),
    .strb_o  (strb),
    .addr_o  (addr),
    .wdata_o (wdata)
  );

  always_comb begin
    mreq   = strb.mreq;
    rd     = strb.rd;
    wr     = strb.wr;
    m1     = strb.m1;
    rfsh   = strb.rfsh;
    done   = strb.done;
    halt_o = halted_i && ((st == ST_IDLE) || (st == ST_F1));
  end

endmodule

// File: rtl/nmi_ack_seq_chk.sv
module nmi_ack_seq_chk #(
  parameter int unsigned     DW      = 8,
  parameter logic [2*DW-1:0] NMI_VEC = 16'h0066
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wait_req,
  input logic            mreq,
  input logic            rd,
  input logic            wr,
  input logic            m1,
  input logic            rfsh,
  input logic            done,
  input logic [2*DW-1:0] pc_out,
  input logic            iff1_out
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd, wr, rfsh}));

  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 && wait_req) |=> m1);

  // R5
  rfsh_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh |-> (mreq && !rd && !m1 && !wr));

  // R6
  wr_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (mreq && !m1));

  // R6
  wr_two_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr) |=> wr);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_out == NMI_VEC));

  // R8
  done_iff1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iff1_out);

endmodule

bind nmi_ack_seq nmi_ack_seq_chk #(.DW(DW), .NMI_VEC(NMI_VEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wait_req (wait_req),
  .mreq     (mreq),
  .rd       (rd),
  .wr       (wr),
  .m1       (m1),
  .rfsh     (rfsh),
  .done     (done),
  .pc_out   (pc_out),
  .iff1_out (iff1_out)
);

// File: tb/nmi_ack_seq_test.sv
module nmi_ack_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_req, wait_req, halted_i, iff1_i;
  logic [15:0] pc_i, sp_i;
  logic        mreq, rd, wr, m1, rfsh, halt_o, iff1_out, iff2_out, done;
  logic [15:0] addr, pc_out, sp_out;
  logic [7:0]  wdata;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  nmi_ack_seq uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .wait_req(wait_req),
    .halted_i(halted_i), .pc_i(pc_i), .sp_i(sp_i), .iff1_i(iff1_i),
    .mreq(mreq), .rd(rd), .wr(wr), .m1(m1), .rfsh(rfsh), .addr(addr),
    .wdata(wdata), .halt_o(halt_o), .pc_out(pc_out), .sp_out(sp_out),
    .iff1_out(iff1_out), .iff2_out(iff2_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // phase code of sequence clock k: 1 T1, 2 T2, 3 wait, 4..6 refresh,
  // 7..9 high write, 10..12 low write, 13 done
  function automatic int phase_of(input int k, input int nw);
    if (k == 1) return 1;
    if (k == 2) return 2;
    if (k <= 2 + nw) return 3;
    return k - nw + 1;
  endfunction

  function automatic logic [5:0] strb_of(input int c);
    logic [5:0] s; // mreq rd wr m1 rfsh done
    s = '0;
    if (c >= 1 && c <= 12) s[5] = 1'b1;
    if (c >= 1 && c <= 3) begin s[4] = 1'b1; s[2] = 1'b1; end
    if (c == 8 || c == 9 || c == 11 || c == 12) s[3] = 1'b1;
    if (c >= 4 && c <= 6) s[1] = 1'b1;
    if (c == 13) s[0] = 1'b1;
    return s;
  endfunction

  task automatic run_case(input logic [15:0] pc, input logic [15:0] sp,
                          input logic i1, input logic h, input int nw,
                          input bit noise, input bit retrig);
    logic [15:0] ret, a_exp;
    logic [7:0]  d_exp;
    int          c;
    string       tag;
    @(negedge clk);
    pc_i = pc; sp_i = sp; iff1_i = i1; halted_i = h; wait_req = 1'b0; nmi_req = 1'b0;
    @(negedge clk);
    chk(halt_o == h, "R9", "idle halt", 32'(halt_o), 32'(h));
    nmi_req = 1'b1;
    ret = h ? pc + 16'd1 : pc;
    for (int k = 1; k <= 12 + nw; k++) begin
      @(negedge clk);
      wait_req = ((k >= 2) && (k < 2 + nw)) || (noise && (k == 1 || k > 2 + nw));
      if (retrig && k == 5) nmi_req = 1'b0;
      if (retrig && k == 6) nmi_req = 1'b1;
      c = phase_of(k, nw);
      tag = (c <= 2) ? "R3" : (c == 3) ? "R4" : (c <= 6) ? "R5" : (c <= 12) ? "R6" : "R7";
      chk({mreq, rd, wr, m1, rfsh, done} == strb_of(c), tag, $sformatf("strobes clk %0d", k),
          32'({mreq, rd, wr, m1, rfsh, done}), 32'(strb_of(c)));
      a_exp = (c <= 3) ? ret : (c >= 7 && c <= 9) ? sp - 16'd1 :
              (c >= 10 && c <= 12) ? sp - 16'd2 : 16'h0000;
      d_exp = (c >= 7 && c <= 9) ? ret[15:8] : (c >= 10 && c <= 12) ? ret[7:0] : 8'h00;
      chk(addr == a_exp, h ? "R10" : "R6", $sformatf("addr clk %0d", k), 32'(addr), 32'(a_exp));
      chk(wdata == d_exp, h ? "R10" : "R6", $sformatf("wdata clk %0d", k), 32'(wdata), 32'(d_exp));
      if (k == 1) chk(halt_o == h, "R9", "halt clk1", 32'(halt_o), 32'(h));
      if (k == 2) chk(halt_o == 1'b0, "R9", "halt clk2", 32'(halt_o), 32'd0);
      if (c == 13) begin
        chk(pc_out == 16'h0066, "R7", "pc_out", 32'(pc_out), 32'h66);
        chk(sp_out == sp - 16'd2, "R6", "sp_out", 32'(sp_out), 32'(sp - 16'd2));
        chk(iff1_out == 1'b0, "R8", "iff1_out", 32'(iff1_out), 32'd0);
        chk(iff2_out == i1, "R8", "iff2_out", 32'(iff2_out), 32'(i1));
      end
    end
    wait_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({mreq, done} == 2'b00, "R2", "no restart on held request", 32'({mreq, done}), 32'd0);
    end
    nmi_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_req = 1'b0; wait_req = 1'b0; halted_i = 1'b0;
    iff1_i = 1'b0; pc_i = '0; sp_i = '0;
    #9;
    chk({mreq, rd, wr, m1, rfsh, done} == 6'b0, "R1", "reset strobes",
        32'({mreq, rd, wr, m1, rfsh, done}), 32'd0);
    chk({addr, wdata} == 24'd0, "R1", "reset bus", 32'({addr, wdata}), 32'd0);
    chk({pc_out, sp_out, iff1_out, iff2_out} == 34'd0, "R1", "reset regs",
        32'({pc_out, iff1_out, iff2_out}), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    run_case(16'h0102, 16'h0000, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    run_case(16'h0101, 16'h0000, 1'b0, 1'b1, 1, 1'b0, 1'b0);
    run_case(16'hFFFF, 16'h0001, 1'b1, 1'b1, 2, 1'b0, 1'b0);
    for (int nw = 0; nw < 4; nw++)
      for (int h = 0; h < 2; h++)
        for (int i1 = 0; i1 < 2; i1++)
          run_case(16'h1234 + 16'(nw * 16'h1111) + 16'(h * 16'h00FF), 16'h8001 + 16'(i1 * 16'h7FFE),
                   1'(i1), 1'(h), nw, i1 == 1, h == 1);

    // reset in the middle of a sequence
    @(negedge clk); nmi_req = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0; #1;
    chk({mreq, rd, wr, m1, rfsh, done} == 6'b0, "R1", "mid reset strobes",
        32'({mreq, rd, wr, m1, rfsh, done}), 32'd0);
    nmi_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(mreq == 1'b0, "R2", "idle after reset", 32'(mreq), 32'd0);
    end
    run_case(16'h4000, 16'h0002, 1'b1, 1'b0, 3, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule